// File: doc/BRIEF.md
# Cascaded Look-Up-Table Cell Chain Self-Tester

This block holds a parameterised row of identical configurable logic cells. Each cell contains an n-input look-up table. One table input is a local input taken from the cell on the left. The other n-1 inputs are common lines, wired in parallel to every cell. The first cell's local input is a primary stimulus bit, and the last cell's output is the observed chain output.

An on-block controller runs a structural test of the chain when `start` is pulsed. It loads every cell with the same truth table at the same time, shifting the table in serially, one bit per clock. It then applies all 2^n input combinations and compares the chain output against the value that a parity cascade must produce. It does this twice: first with every table set to parity (XOR), then with every table set to inverted parity (XNOR). Because the tables form a cascade of parity functions, a stuck value anywhere in the row changes the chain output for some vector.

The first mismatch is latched together with its configuration index and vector number, and a sticky fail flag is raised. A fault-injection port can force the output of any one cell to a constant. This lets a bench or a bring-up flow confirm that the tester catches a stuck cell.

Top module: `lut_chain_tester`

## Requirements
- R1: After reset, `busy`, `cfg_done`, `finished` and `fail` are 0.
- R2: Each configuration is loaded in exactly 2^n clocks and is followed by a one-cycle `cfg_done` pulse. A run contains exactly two such pulses. `finished` rises 4·2^n+2 clocks after the clock edge that samples `start`.
- R3: Truth-table entry a holds the parity of a in configuration 0 (XOR) and the inverted parity in configuration 1 (XNOR). Address bit 0 is the local input, and address bits n-1..1 are the common inputs.
- R4: Cell 0 takes stimulus bit 0 as its local input. Cell i>0 takes the output of cell i-1. Stimulus bits n-1..1 drive the common inputs of every cell. `chain_out` is the output of the last cell.
- R5: In each configuration the vectors 0 to 2^n-1 are applied in ascending order, one per clock, starting the cycle after `cfg_done`. Configuration 0 runs before configuration 1.
- R6: A run with no injected fault ends with `finished`=1 and `fail`=0.
- R7: On the first mismatch, `fail` goes to 1, and `fail_cfg` and `fail_vec` record the configuration index and vector of that mismatch. All three hold until the next accepted `start`.
- R8: While `fault_en` is 1, the output of the cell numbered `fault_cell` is forced to `fault_val`.
- R9: A `start` pulse while `busy` is 1 has no effect on the run, its length or its result.
- R10: A `start` accepted while idle or finished clears `fail` and begins a new run with `busy`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run when not busy |
| fault_en | input | 1 | Enable stuck-output injection |
| fault_cell | input | CELL_W | Index of the cell whose output is forced |
| fault_val | input | 1 | Value forced on the selected cell output |
| busy | output | 1 | Run in progress |
| cfg_done | output | 1 | One-cycle pulse after a configuration is loaded |
| finished | output | 1 | Run complete, result valid |
| fail | output | 1 | Sticky mismatch flag |
| fail_cfg | output | 1 | Configuration index of the first mismatch |
| fail_vec | output | LUT_INPUTS | Vector number of the first mismatch |
| chain_out | output | 1 | Output of the last cell in the row |

## Verification
The chain is exercised with a fault-free row and with stuck-at-0 and stuck-at-1 forced on the first, middle and last cells. The fault-free case shows that both parity tables load and cascade correctly. Each forced case shows whether the first failing configuration and vector match the one a reference cascade predicts. A stuck fault on the first cell separates errors in local-input routing from errors in the common-input fan-out, because its effect must travel through every later cell. During each run, `chain_out` is compared on every applied vector. This compare separates a wrong table bit order or a wrong vector order from a correct result that happens to arrive by chance. A start pulse in the middle of a run and a restart after a failing run check that the run is protected while busy and that the fail state clears on a new run.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CDONE,
    ST_APPLY,
    ST_END
  } lct_state_e;
endpackage

// File: rtl/lct_cell.sv
module lct_cell #(
  parameter int LUT_INPUTS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  shift_bit,
  input  logic                  local_i,
  input  logic [LUT_INPUTS-2:0] common_i,
  input  logic                  force_en,
  input  logic                  force_val,
  output logic                  out_o
);
  localparam int ENTRIES = 1 << LUT_INPUTS;

  logic [ENTRIES-1:0]    tbl_q, tbl_d;
  logic [LUT_INPUTS-1:0] addr;
  logic                  lut_val;

  // serial load: the first bit shifted in ends up in the top entry
  always_comb begin
    tbl_d = tbl_q;
    if (shift_en) tbl_d = {tbl_q[ENTRIES-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= tbl_d;
  end

  assign addr    = {common_i, local_i};
  assign lut_val = tbl_q[addr];
  assign out_o   = force_en ? force_val : lut_val;
endmodule

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
#(
  parameter int LUT_INPUTS = 3,
  parameter int NUM_CELLS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  chain_i,
  output logic                  shift_en_o,
  output logic                  shift_bit_o,
  output logic [LUT_INPUTS-1:0] vec_o,
  output logic                  busy_o,
  output logic                  cfg_done_o,
  output logic                  finished_o,
  output logic                  fail_o,
  output logic                  fail_cfg_o,
  output logic [LUT_INPUTS-1:0] fail_vec_o
);
  localparam logic [LUT_INPUTS-1:0] LAST = '1;
  localparam bit ODD_ROW = (NUM_CELLS % 2) == 1;

  lct_state_e            state_q, state_d;
  logic [LUT_INPUTS-1:0] cnt_q, cnt_d;
  logic                  cfg_q, cfg_d;
  logic                  fail_q, fail_d;
  logic                  fcfg_q, fcfg_d;
  logic [LUT_INPUTS-1:0] fvec_q, fvec_d;
  logic                  expect_bit;
  logic                  mismatch;

  // cascade of N parity stages: odd N leaves one copy of (common parity ^ cfg)
  assign expect_bit = cnt_q[0] ^ (ODD_ROW ? ((^cnt_q[LUT_INPUTS-1:1]) ^ cfg_q) : 1'b0);
  assign mismatch   = (state_q == ST_APPLY) && (chain_i != expect_bit);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cfg_d   = cfg_q;
    fail_d  = fail_q;
    fcfg_d  = fcfg_q;
    fvec_d  = fvec_q;
    unique case (state_q)
      ST_IDLE, ST_END: begin
        if (start_i) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
          cfg_d   = 1'b0;
          fail_d  = 1'b0;
          fcfg_d  = 1'b0;
          fvec_d  = '0;
        end
      end
      ST_LOAD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_CDONE;
      end
      ST_CDONE: begin
        state_d = ST_APPLY;
        cnt_d   = '0;
      end
      ST_APPLY: begin
        cnt_d = cnt_q + 1'b1;
        if (mismatch && !fail_q) begin
          fail_d = 1'b1;
          fcfg_d = cfg_q;
          fvec_d = cnt_q;
        end
        if (cnt_q == LAST) begin
          if (cfg_q) begin
            state_d = ST_END;
          end else begin
            state_d = ST_LOAD;
            cfg_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cfg_q   <= 1'b0;
      fail_q  <= 1'b0;
      fcfg_q  <= 1'b0;
      fvec_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      fail_q  <= fail_d;
      fcfg_q  <= fcfg_d;
      fvec_q  <= fvec_d;
    end
  end

  // entry index loaded now is ~cnt (top entry first); value = parity ^ cfg
  assign shift_en_o  = (state_q == ST_LOAD);
  assign shift_bit_o = (^(~cnt_q)) ^ cfg_q;
  assign vec_o       = cnt_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_END);
  assign cfg_done_o  = (state_q == ST_CDONE);
  assign finished_o  = (state_q == ST_END);
  assign fail_o      = fail_q;
  assign fail_cfg_o  = fcfg_q;
  assign fail_vec_o  = fvec_q;
endmodule

// File: rtl/lut_chain_tester.sv
module lut_chain_tester #(
  parameter int NUM_CELLS  = 4,
  parameter int LUT_INPUTS = 3,
  parameter int CELL_W     = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  fault_en,
  input  logic [CELL_W-1:0]     fault_cell,
  input  logic                  fault_val,
  output logic                  busy,
  output logic                  cfg_done,
  output logic                  finished,
  output logic                  fail,
  output logic                  fail_cfg,
  output logic [LUT_INPUTS-1:0] fail_vec,
  output logic                  chain_out
);
  logic                  shift_en, shift_bit;
  logic [LUT_INPUTS-1:0] vec;
  logic [NUM_CELLS:0]    link;

  assign link[0] = vec[0];

  lct_ctrl #(.LUT_INPUTS(LUT_INPUTS), .NUM_CELLS(NUM_CELLS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chain_i(link[NUM_CELLS]),
    .shift_en_o(shift_en), .shift_bit_o(shift_bit), .vec_o(vec),
    .busy_o(busy), .cfg_done_o(cfg_done), .finished_o(finished),
    .fail_o(fail), .fail_cfg_o(fail_cfg), .fail_vec_o(fail_vec)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic force_here;
    assign force_here = fault_en && (fault_cell == CELL_W'(i));
    lct_cell #(.LUT_INPUTS(LUT_INPUTS)) cell_i (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_bit(shift_bit),
      .local_i(link[i]), .common_i(vec[LUT_INPUTS-1:1]),
      .force_en(force_here), .force_val(fault_val), .out_o(link[i+1])
    );
  end

  assign chain_out = link[NUM_CELLS];
endmodule

// File: rtl/lut_chain_tester_chk.sv
module lut_chain_tester_chk #(
  parameter int NUM_CELLS  = 4,
  parameter int LUT_INPUTS = 3,
  parameter int CELL_W     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  fault_en,
  input logic [CELL_W-1:0]     fault_cell,
  input logic                  fault_val,
  input logic                  busy,
  input logic                  cfg_done,
  input logic                  finished,
  input logic                  fail,
  input logic                  fail_cfg,
  input logic [LUT_INPUTS-1:0] fail_vec,
  input logic                  chain_out
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  p_done_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> busy);

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  p_fail_info_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> ($stable(fail_cfg) && $stable(fail_vec)));

  p_end_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !busy);

  p_last_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_en && fault_cell == CELL_W'(NUM_CELLS-1)) |-> (chain_out == fault_val));

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fail) |=> !fail || busy);

  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !fail));
endmodule

bind lut_chain_tester lut_chain_tester_chk #(
  .NUM_CELLS(NUM_CELLS), .LUT_INPUTS(LUT_INPUTS), .CELL_W(CELL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .fault_en(fault_en),
  .fault_cell(fault_cell), .fault_val(fault_val), .busy(busy),
  .cfg_done(cfg_done), .finished(finished), .fail(fail),
  .fail_cfg(fail_cfg), .fail_vec(fail_vec), .chain_out(chain_out)
);

// File: tb/lut_chain_tester_tb_top.sv
module lut_chain_tester_tb_top;
  localparam int NC = 4;
  localparam int LI = 3;
  localparam int CW = 2;
  localparam int W  = 1 << LI;

  typedef struct {
    bit fail;
    bit cfg;
    int vec;
    int c0;
  } exp_t;

  logic clk, rst_n, start, fault_en, fault_val;
  logic [CW-1:0] fault_cell;
  logic busy, cfg_done, finished, fail, fail_cfg, chain_out;
  logic [LI-1:0] fail_vec;

  int checks = 0, errors = 0, cyc = 0;
  int pulses = 0;
  bit fin_prev = 0;
  bit done_flag = 0;
  exp_t sbq[$];

  lut_chain_tester #(.NUM_CELLS(NC), .LUT_INPUTS(LI), .CELL_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_en(fault_en),
    .fault_cell(fault_cell), .fault_val(fault_val), .busy(busy),
    .cfg_done(cfg_done), .finished(finished), .fail(fail),
    .fail_cfg(fail_cfg), .fail_vec(fail_vec), .chain_out(chain_out)
  );

  initial clk = 0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference cascade built from R3/R4 with optional stuck cell (R8)
  function automatic bit model(input bit cfg, input int v, input bit fen,
                               input int fcell, input bit fval);
    logic [LI-1:0] vv;
    bit o, p;
    vv = v[LI-1:0];
    o  = vv[0];
    p  = ^vv[LI-1:1];
    for (int c = 0; c < NC; c++) begin
      if (fen && c == fcell) o = fval;
      else                   o = o ^ p ^ cfg;
    end
    return o;
  endfunction

  task automatic run(input bit fen, input int fcell, input bit fval, input bit glitch);
    exp_t e;
    e.fail = 0; e.cfg = 0; e.vec = 0;
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < W; v++)
        if (!e.fail && model(c[0], v, fen, fcell, fval) != model(c[0], v, 0, 0, 0)) begin
          e.fail = 1; e.cfg = c[0]; e.vec = v;
        end
    @(negedge clk);
    fault_en = fen; fault_cell = fcell[CW-1:0]; fault_val = fval;
    start = 1;
    @(negedge clk);
    start = 0;
    e.c0 = cyc;
    sbq.push_back(e);
    chk(busy === 1'b1 && fail === 1'b0, "R10 start accepted, fail cleared", {busy, fail}, 2);
    for (int c = 0; c < 2; c++) begin
      while (cfg_done !== 1'b1) @(negedge clk);
      for (int v = 0; v < W; v++) begin
        @(negedge clk);
        if (glitch && c == 0 && v == 2) start = 1;
        else start = 0;
        chk(chain_out === model(c[0], v, fen, fcell, fval),
            $sformatf("R3/R4/R5 chain cfg%0d vec%0d", c, v),
            chain_out, model(c[0], v, fen, fcell, fval));
      end
      start = 0;
    end
    while (finished !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_done === 1'b1) pulses++;
      if (finished === 1'b1 && !fin_prev) begin
        exp_t e;
        if (sbq.size() == 0) begin
          chk(0, "R2 unexpected finish", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk(cyc - e.c0 == 4*W + 2, "R2 run length", cyc - e.c0, 4*W + 2);
          chk(pulses == 2, "R2 cfg_done pulses", pulses, 2);
          chk(fail === e.fail, e.fail ? "R7 fail flag" : "R6 clean run", fail, e.fail);
          if (e.fail) begin
            chk(fail_cfg === e.cfg, "R7 fail_cfg", fail_cfg, e.cfg);
            chk(int'(fail_vec) == e.vec, "R7 fail_vec", fail_vec, e.vec);
          end
        end
        pulses = 0;
      end
      fin_prev = (finished === 1'b1);
    end
  end

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; fault_en = 0; fault_cell = '0; fault_val = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && cfg_done === 0 && finished === 0 && fail === 0,
        "R1 reset state", {busy, cfg_done, finished, fail}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && finished === 0, "R1 idle after reset", {busy, finished}, 0);

    run(0, 0, 0, 0);        // R6 fault-free
    run(1, 0, 0, 0);        // R8 first cell stuck-at-0
    @(negedge clk);
    chk(fail === 1'b1, "R7 fail held while finished", fail, 1);
    run(1, NC-1, 1, 0);     // R8 last cell stuck-at-1
    run(1, 2, 1, 0);        // R8 middle cell stuck-at-1
    run(1, 1, 0, 1);        // R9 start glitch mid-run, second cell stuck-at-0
    run(0, 0, 0, 1);        // R9 glitch on clean run, R10 restart after fail

    // R8 direct: force last cell while idle, observe chain output
    @(negedge clk);
    fault_en = 1; fault_cell = CW'(NC-1); fault_val = 1;
    @(negedge clk);
    chk(chain_out === 1'b1, "R8 forced high at output", chain_out, 1);
    fault_val = 0;
    @(negedge clk);
    chk(chain_out === 1'b0, "R8 forced low at output", chain_out, 0);
    fault_en = 0;

    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R2 all runs scored", sbq.size(), 0);
    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule